// File: doc/BRIEF.md
# Multicast Copy and Destination MAC Unit

This unit sits between packet classification and the queue manager. It accepts one forwarding decision per packet. A decision holds a buffer handle, a unicast/multicast flag, the IP destination address, a next-hop MAC with a valid flag, a destination code, a queue id, a copy mask and a statistics index. From that decision the unit first writes the packet's buffer descriptor: the destination MAC, the statistics index and the number of copies that will refer to the buffer. After the last descriptor write it issues enqueue requests.

A unicast packet that has a usable MAC produces one enqueue request. A multicast packet produces one request for each set bit of its copy mask, in ascending bit order, at most one per cycle. A packet that would produce no copies writes nothing to its descriptor. Its handle is returned on a free strobe instead.

Destination codes 0 to 4 name output ports and 5 to 9 name plugins. Every port copy of a packet carries the queue id from the decision. Plugin copies carry a queue id of zero. All copies share the one descriptor, so the MAC and the reference count are written only once.

Top module: `mcast_copy_unit`

## Requirements
- R1: After reset, `in_ready` is 1 and `dw_valid`, `eq_valid` and `free_valid` are 0.
- R2: For a packet that is not dropped, exactly three descriptor writes occur, one per cycle, all with `dw_addr` equal to the handle. They use `dw_sel` 0, then 1, then 2, and the last one completes before the first enqueue request is shown.
- R3: Descriptor word layout: select 0 carries {MAC[47:32], stats index[15:0]}, select 1 carries MAC[31:0], and select 2 carries the reference count in bits 3:0 with the upper bits zero. For unicast, the MAC is the next-hop MAC and exactly one enqueue goes to `in_dest`.
- R4: For multicast, the MAC is 0x01005E followed by a zero bit and IP destination bits 22:0.
- R5: The reference count equals the number of enqueue requests the packet produces: the popcount of the copy mask for multicast, and 1 for unicast.
- R6: Multicast copies go out one per set mask bit, in ascending bit order. `eq_dest` equals the bit index, where bits 0 to 4 are ports and bits 5 to 9 are plugins.
- R7: A copy to a port carries the decision's queue id. A copy to a plugin (`eq_dest` 5 to 9) carries a queue id of 0.
- R8: While `eq_valid` is high and `eq_ready` is low, the request holds stable. Under backpressure no copy is lost or repeated.
- R9: A multicast packet with an all-zero copy mask makes no descriptor write and no enqueue. It makes one `free_valid` pulse with `free_handle` equal to the handle.
- R10: A unicast packet with `in_mac_ok` = 0 is dropped in the same way as in R9.
- R11: `in_ready` is 0 from the cycle after a decision is accepted until its last write, enqueue or free has completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Decision record valid |
| in_ready | output | 1 | Unit can accept a decision |
| in_handle | input | HANDLE_W | Buffer handle of the packet |
| in_mcast | input | 1 | 1 = multicast, 0 = unicast |
| in_dst_ip | input | 32 | IP destination address |
| in_nh_mac | input | 48 | Next-hop MAC for unicast |
| in_mac_ok | input | 1 | Next-hop MAC is valid |
| in_dest | input | DEST_W | Unicast destination code (0-4 port, 5-9 plugin) |
| in_qid | input | QID_W | Queue id for port copies |
| in_copy_vec | input | NPORT+NPLUG | Multicast copy mask |
| in_stats | input | 16 | Statistics index |
| dw_valid | output | 1 | Descriptor write strobe |
| dw_addr | output | HANDLE_W | Descriptor handle being written |
| dw_sel | output | 2 | Descriptor word select (0, 1, 2) |
| dw_data | output | 32 | Descriptor word data |
| eq_valid | output | 1 | Enqueue request valid |
| eq_ready | input | 1 | Queue manager accepts request |
| eq_handle | output | HANDLE_W | Buffer handle of the copy |
| eq_dest | output | DEST_W | Destination code of the copy |
| eq_qid | output | QID_W | Queue id of the copy |
| free_valid | output | 1 | Drop: buffer free strobe |
| free_handle | output | HANDLE_W | Handle to free |

## Verification
The hardest case to reach is a multicast packet that spans all ten destinations while the queue manager stalls irregularly. Only that case shows the hold rule, the ascending order and the port/plugin queue-id switch together. The bench drives the full mask and a sparse mask with `eq_ready` following a repeating two-of-three pattern. It logs every accepted request at the ports and compares that log with the list it builds from the mask. Drops are checked the same way, by seeing that no write or enqueue appears before the unit is ready again.

// File: rtl/mcu_pkg.sv
package mcu_pkg;
    // Width of the descriptor reference count field
    localparam int unsigned RC_W    = 4;
    // Width of the statistics index
    localparam int unsigned STATS_W = 16;

    // Descriptor word selects, in the order they are written
    localparam logic [1:0] SEL_HI = 2'd0;
    localparam logic [1:0] SEL_LO = 2'd1;
    localparam logic [1:0] SEL_RC = 2'd2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WHI,
        ST_WLO,
        ST_WRC,
        ST_EMIT,
        ST_DROP
    } mcu_state_e;

    // Group MAC derived from an IP group address
    function automatic logic [47:0] group_mac(input logic [31:0] ip);
        return {24'h01005E, 1'b0, ip[22:0]};
    endfunction
endpackage

// File: rtl/mcu_mac_former.sv
// Forms the destination MAC, the set of copies and the reference count
// for one decision record.
// Assumes VEC_W is below 2**RC_W, so the popcount cannot overflow.
module mcu_mac_former
    import mcu_pkg::*;
#(
    parameter int unsigned VEC_W  = 10,
    parameter int unsigned DEST_W = 4
) (
    input  logic              is_mcast,
    input  logic [31:0]       dst_ip,
    input  logic [47:0]       nh_mac,
    input  logic [DEST_W-1:0] dest,
    input  logic [VEC_W-1:0]  vec,
    output logic [47:0]       mac,
    output logic [VEC_W-1:0]  copy_set,
    output logic [RC_W-1:0]   ref_cnt
);
    // Pick the MAC source by packet kind
    always_comb begin
        mac = is_mcast ? group_mac(dst_ip) : nh_mac;
    end

    // Copy set: the mask for multicast, the single destination for unicast
    always_comb begin
        copy_set = '0;
        if (is_mcast) begin
            copy_set = vec;
        end else if (32'(dest) < VEC_W) begin
            copy_set[dest] = 1'b1;
        end
    end

    // Count the copies
    always_comb begin
        ref_cnt = '0;
        for (int i = 0; i < VEC_W; i++) begin
            ref_cnt = ref_cnt + RC_W'(copy_set[i]);
        end
    end
endmodule

// File: rtl/mcu_copy_picker.sv
// Chooses the lowest pending copy bit.
// Assumes the caller clears a granted bit once it is accepted.
module mcu_copy_picker #(
    parameter int unsigned VEC_W  = 10,
    parameter int unsigned DEST_W = 4
) (
    input  logic [VEC_W-1:0]  pend,
    output logic              any,
    output logic [DEST_W-1:0] idx,
    output logic [VEC_W-1:0]  grant
);
    // Scan from the top so the lowest set bit wins
    always_comb begin
        idx   = '0;
        grant = '0;
        for (int i = VEC_W - 1; i >= 0; i--) begin
            if (pend[i]) begin
                idx      = DEST_W'(i);
                grant    = '0;
                grant[i] = 1'b1;
            end
        end
        any = |pend;
    end
endmodule

// File: rtl/mcast_copy_unit.sv
// Takes one forwarding decision, writes the shared descriptor (MAC,
// statistics index, reference count) and then issues one enqueue per copy.
// Packets with no copies are freed instead.
// Assumes the descriptor write port always accepts and eq_ready may stall.
module mcast_copy_unit
    import mcu_pkg::*;
#(
    parameter  int unsigned HANDLE_W = 20,
    parameter  int unsigned QID_W    = 17,
    parameter  int unsigned NPORT    = 5,
    parameter  int unsigned NPLUG    = 5,
    localparam int unsigned VEC_W    = NPORT + NPLUG,
    localparam int unsigned DEST_W   = $clog2(VEC_W)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [HANDLE_W-1:0] in_handle,
    input  logic                in_mcast,
    input  logic [31:0]         in_dst_ip,
    input  logic [47:0]         in_nh_mac,
    input  logic                in_mac_ok,
    input  logic [DEST_W-1:0]   in_dest,
    input  logic [QID_W-1:0]    in_qid,
    input  logic [VEC_W-1:0]    in_copy_vec,
    input  logic [STATS_W-1:0]  in_stats,
    output logic                dw_valid,
    output logic [HANDLE_W-1:0] dw_addr,
    output logic [1:0]          dw_sel,
    output logic [31:0]         dw_data,
    output logic                eq_valid,
    input  logic                eq_ready,
    output logic [HANDLE_W-1:0] eq_handle,
    output logic [DEST_W-1:0]   eq_dest,
    output logic [QID_W-1:0]    eq_qid,
    output logic                free_valid,
    output logic [HANDLE_W-1:0] free_handle
);
    mcu_state_e          st_q;
    logic [HANDLE_W-1:0] hnd_q;
    logic [47:0]         mac_q;
    logic [STATS_W-1:0]  stats_q;
    logic [QID_W-1:0]    qid_q;
    logic [RC_W-1:0]     rc_q;
    logic [VEC_W-1:0]    pend_q;

    logic [47:0]         mac_c;
    logic [VEC_W-1:0]    set_c;
    logic [RC_W-1:0]     rc_c;
    logic                drop_c;
    logic                pick_any;
    logic [DEST_W-1:0]   pick_idx;
    logic [VEC_W-1:0]    pick_grant;
    logic [VEC_W-1:0]    pend_left;

    mcu_mac_former #(.VEC_W(VEC_W), .DEST_W(DEST_W)) former_i (
        .is_mcast (in_mcast),
        .dst_ip   (in_dst_ip),
        .nh_mac   (in_nh_mac),
        .dest     (in_dest),
        .vec      (in_copy_vec),
        .mac      (mac_c),
        .copy_set (set_c),
        .ref_cnt  (rc_c)
    );

    mcu_copy_picker #(.VEC_W(VEC_W), .DEST_W(DEST_W)) picker_i (
        .pend  (pend_q),
        .any   (pick_any),
        .idx   (pick_idx),
        .grant (pick_grant)
    );

    // Drop when no copy would result or a unicast MAC is missing
    always_comb begin
        drop_c = (set_c == '0) || (!in_mcast && !in_mac_ok);
    end

    // Copies still owed after the current grant
    always_comb begin
        pend_left = pend_q & ~pick_grant;
    end

    // Sequencer: capture, three descriptor writes, emit copies or drop
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            hnd_q   <= '0;
            mac_q   <= '0;
            stats_q <= '0;
            qid_q   <= '0;
            rc_q    <= '0;
            pend_q  <= '0;
        end else begin
            case (st_q)
                ST_IDLE: if (in_valid) begin
                    hnd_q   <= in_handle;
                    mac_q   <= mac_c;
                    stats_q <= in_stats;
                    qid_q   <= in_qid;
                    rc_q    <= rc_c;
                    pend_q  <= drop_c ? '0 : set_c;
                    st_q    <= drop_c ? ST_DROP : ST_WHI;
                end
                ST_WHI: st_q <= ST_WLO;
                ST_WLO: st_q <= ST_WRC;
                ST_WRC: st_q <= ST_EMIT;
                ST_EMIT: if (eq_ready && pick_any) begin
                    pend_q <= pend_left;
                    if (pend_left == '0) begin
                        st_q <= ST_IDLE;
                    end
                end
                ST_DROP: st_q <= ST_IDLE;
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // Input handshake
    always_comb begin
        in_ready = (st_q == ST_IDLE);
    end

    // Descriptor write port
    always_comb begin
        dw_valid = 1'b0;
        dw_sel   = SEL_HI;
        dw_data  = '0;
        dw_addr  = hnd_q;
        case (st_q)
            ST_WHI: begin
                dw_valid = 1'b1;
                dw_sel   = SEL_HI;
                dw_data  = {mac_q[47:32], stats_q};
            end
            ST_WLO: begin
                dw_valid = 1'b1;
                dw_sel   = SEL_LO;
                dw_data  = mac_q[31:0];
            end
            ST_WRC: begin
                dw_valid = 1'b1;
                dw_sel   = SEL_RC;
                dw_data  = {{(32 - RC_W){1'b0}}, rc_q};
            end
            default: ;
        endcase
    end

    // Enqueue request: plugin copies carry no queue id
    always_comb begin
        eq_valid  = (st_q == ST_EMIT) && pick_any;
        eq_handle = hnd_q;
        eq_dest   = pick_idx;
        eq_qid    = (32'(pick_idx) < NPORT) ? qid_q : '0;
    end

    // Free strobe on drop
    always_comb begin
        free_valid  = (st_q == ST_DROP);
        free_handle = hnd_q;
    end

    // R11: no output activity while the input side is open
    a_r11_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (dw_valid || eq_valid || free_valid) |-> !in_ready);

    // R8: a stalled request holds
    a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (eq_valid && !eq_ready) |=> (eq_valid && $stable(eq_dest)
                                     && $stable(eq_handle) && $stable(eq_qid)));

    // R2: the reference count write is followed directly by an enqueue
    a_r2_write_then_enqueue: assert property (@(posedge clk) disable iff (!rst_n)
        (dw_valid && dw_sel == SEL_RC) |=> eq_valid);

    // R7: plugin copies carry queue id zero
    a_r7_plugin_qid: assert property (@(posedge clk) disable iff (!rst_n)
        (eq_valid && 32'(eq_dest) >= NPORT) |-> (eq_qid == '0));

    // R6: successive accepted copies rise in destination order
    a_r6_ascending: assert property (@(posedge clk) disable iff (!rst_n)
        (eq_valid && eq_ready) |=> (!eq_valid || eq_dest > $past(eq_dest)));

    // R9: a drop touches neither the descriptor nor the queue manager
    a_r9_drop_alone: assert property (@(posedge clk) disable iff (!rst_n)
        free_valid |-> (!dw_valid && !eq_valid));
endmodule

// File: tb/mcast_copy_unit_tb_top.sv
module mcast_copy_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int HW = 20;
    localparam int QW = 17;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [HW-1:0] in_handle = '0;
    logic          in_mcast = 1'b0;
    logic [31:0]   in_dst_ip = '0;
    logic [47:0]   in_nh_mac = '0;
    logic          in_mac_ok = 1'b0;
    logic [3:0]    in_dest = '0;
    logic [QW-1:0] in_qid = '0;
    logic [9:0]    in_copy_vec = '0;
    logic [15:0]   in_stats = '0;
    logic          dw_valid;
    logic [HW-1:0] dw_addr;
    logic [1:0]    dw_sel;
    logic [31:0]   dw_data;
    logic          eq_valid;
    logic          eq_ready = 1'b1;
    logic [HW-1:0] eq_handle;
    logic [3:0]    eq_dest;
    logic [QW-1:0] eq_qid;
    logic          free_valid;
    logic [HW-1:0] free_handle;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit bp_on  = 1'b0;
    bit done   = 1'b0;

    // Port logs filled by the monitor
    int            ev;
    int            dw_n, eq_n, fr_n;
    int            last_dw_ev, first_eq_ev;
    logic [1:0]    dw_sel_l  [16];
    logic [31:0]   dw_data_l [16];
    logic [HW-1:0] dw_addr_l [16];
    logic [3:0]    eq_dest_l [16];
    logic [QW-1:0] eq_qid_l  [16];
    logic [HW-1:0] eq_hnd_l  [16];
    logic [HW-1:0] fr_hnd;

    mcast_copy_unit dut_i (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_handle(in_handle),
        .in_mcast(in_mcast), .in_dst_ip(in_dst_ip), .in_nh_mac(in_nh_mac),
        .in_mac_ok(in_mac_ok), .in_dest(in_dest), .in_qid(in_qid),
        .in_copy_vec(in_copy_vec), .in_stats(in_stats),
        .dw_valid(dw_valid), .dw_addr(dw_addr), .dw_sel(dw_sel), .dw_data(dw_data),
        .eq_valid(eq_valid), .eq_ready(eq_ready), .eq_handle(eq_handle),
        .eq_dest(eq_dest), .eq_qid(eq_qid),
        .free_valid(free_valid), .free_handle(free_handle)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Ready pattern: always ready, or ready two cycles in three
    always @(posedge clk) begin
        cyc = cyc + 1;
        #1;
        eq_ready = bp_on ? ((cyc % 3) != 0) : 1'b1;
    end

    // Monitor: log transfers between edges
    always @(negedge clk) begin
        if (rst_n) begin
            if (dw_valid && dw_n < 16) begin
                dw_sel_l[dw_n] = dw_sel; dw_data_l[dw_n] = dw_data;
                dw_addr_l[dw_n] = dw_addr; dw_n++; last_dw_ev = ev;
            end
            if (eq_valid && eq_ready && eq_n < 16) begin
                if (eq_n == 0) first_eq_ev = ev;
                eq_dest_l[eq_n] = eq_dest; eq_qid_l[eq_n] = eq_qid;
                eq_hnd_l[eq_n] = eq_handle; eq_n++;
            end
            if (free_valid) begin
                fr_n++; fr_hnd = free_handle;
            end
            ev++;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    function automatic int pop10(input logic [9:0] v);
        int n = 0;
        for (int i = 0; i < 10; i++) n += int'(v[i]);
        return n;
    endfunction

    // Send one decision, wait for completion and check every port effect
    task automatic do_packet(input logic [HW-1:0] h, input bit mc, input logic [31:0] ip,
                             input logic [47:0] nmac, input bit mok, input logic [3:0] dst,
                             input logic [QW-1:0] q, input logic [9:0] vec,
                             input logic [15:0] st);
        logic [9:0]  set;
        logic [47:0] emac;
        bit          drop;
        int          rc, k, guard;
        dw_n = 0; eq_n = 0; fr_n = 0; last_dw_ev = 0; first_eq_ev = 0; fr_hnd = '0;
        set  = mc ? vec : ((dst < 10) ? (10'd1 << dst) : 10'd0);
        drop = (set == 0) || (!mc && !mok);
        emac = mc ? {24'h01005E, 1'b0, ip[22:0]} : nmac;
        rc   = pop10(set);
        @(posedge clk); #2;
        in_handle = h; in_mcast = mc; in_dst_ip = ip; in_nh_mac = nmac; in_mac_ok = mok;
        in_dest = dst; in_qid = q; in_copy_vec = vec; in_stats = st; in_valid = 1'b1;
        guard = 0;
        do begin @(negedge clk); guard++; end while (!in_ready && guard < 50);
        @(posedge clk); #2; in_valid = 1'b0;
        @(negedge clk);
        check(in_ready == 1'b0, "R11", "in_ready after accept", 64'(in_ready), 0);
        guard = 0;
        while (!in_ready && guard < 200) begin @(negedge clk); guard++; end
        if (drop) begin
            check(dw_n == 0, mc ? "R9" : "R10", "descriptor writes", 64'(dw_n), 0);
            check(eq_n == 0, mc ? "R9" : "R10", "enqueues", 64'(eq_n), 0);
            check(fr_n == 1, mc ? "R9" : "R10", "free pulses", 64'(fr_n), 1);
            check(fr_hnd == h, mc ? "R9" : "R10", "free handle", 64'(fr_hnd), 64'(h));
        end else begin
            check(fr_n == 0, "R9", "no free", 64'(fr_n), 0);
            check(dw_n == 3, "R2", "write count", 64'(dw_n), 3);
            for (int i = 0; i < 3 && i < dw_n; i++) begin
                check(dw_sel_l[i] == 2'(i), "R2", "write select", 64'(dw_sel_l[i]), 64'(i));
                check(dw_addr_l[i] == h, "R2", "write addr", 64'(dw_addr_l[i]), 64'(h));
            end
            check(last_dw_ev < first_eq_ev, "R2", "writes precede enqueue",
                  64'(last_dw_ev), 64'(first_eq_ev));
            check(dw_data_l[0] == {emac[47:32], st}, mc ? "R4" : "R3", "word0",
                  64'(dw_data_l[0]), 64'({emac[47:32], st}));
            check(dw_data_l[1] == emac[31:0], mc ? "R4" : "R3", "word1",
                  64'(dw_data_l[1]), 64'(emac[31:0]));
            check(dw_data_l[2] == 32'(rc), "R5", "ref count", 64'(dw_data_l[2]), 64'(rc));
            check(eq_n == rc, "R8", "enqueue count", 64'(eq_n), 64'(rc));
            k = 0;
            for (int b = 0; b < 10; b++) begin
                if (set[b] && k < eq_n) begin
                    check(eq_dest_l[k] == 4'(b), mc ? "R6" : "R3", "copy dest",
                          64'(eq_dest_l[k]), 64'(b));
                    check(eq_qid_l[k] == ((b < 5) ? q : '0), "R7", "copy qid",
                          64'(eq_qid_l[k]), 64'((b < 5) ? q : '0));
                    check(eq_hnd_l[k] == h, "R6", "copy handle", 64'(eq_hnd_l[k]), 64'(h));
                    k++;
                end
            end
        end
    endtask

    task automatic t_reset;
        @(negedge clk);
        check(in_ready == 1'b1, "R1", "in_ready", 64'(in_ready), 1);
        check(!dw_valid && !eq_valid && !free_valid, "R1", "outputs idle",
              64'({dw_valid, eq_valid, free_valid}), 0);
    endtask

    task automatic t_unicast_port;
        do_packet(20'h0A5C3, 1'b0, 32'h0A000001, 48'hA1B2C3D4E5F6, 1'b1, 4'd2,
                  17'h1ABCD, 10'h3FF, 16'h1234);
    endtask

    task automatic t_unicast_plugin;
        do_packet(20'h00777, 1'b0, 32'h0A000002, 48'h0203040506AA, 1'b1, 4'd7,
                  17'h00055, 10'h000, 16'hBEEF);
    endtask

    task automatic t_unicast_nomac;
        do_packet(20'h12345, 1'b0, 32'h0A000003, 48'h111111111111, 1'b0, 4'd1,
                  17'h00003, 10'h000, 16'h0001);
    endtask

    task automatic t_mcast_sparse;
        do_packet(20'hFEDCB, 1'b1, 32'hE1FF8001, 48'h0, 1'b0, 4'd0,
                  17'h0F0F0, 10'b1010010101, 16'h5A5A);
    endtask

    task automatic t_mcast_all_bp;
        bp_on = 1'b1;
        do_packet(20'h00042, 1'b1, 32'hEFFFFFFF, 48'h0, 1'b0, 4'd0,
                  17'h1FFFF, 10'h3FF, 16'hFFFF);
        bp_on = 1'b0;
    endtask

    task automatic t_mcast_top_plugin_bp;
        bp_on = 1'b1;
        do_packet(20'h00900, 1'b1, 32'hE0000101, 48'h0, 1'b0, 4'd0,
                  17'h00011, 10'b1000000000, 16'h0900);
        bp_on = 1'b0;
    endtask

    task automatic t_mcast_zero;
        do_packet(20'h0ABCD, 1'b1, 32'hE0000001, 48'h0, 1'b1, 4'd0,
                  17'h00001, 10'h000, 16'h0002);
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        t_reset();
        t_unicast_port();
        t_unicast_plugin();
        t_unicast_nomac();
        t_mcast_sparse();
        t_mcast_all_bp();
        t_mcast_top_plugin_bp();
        t_mcast_zero();
        t_unicast_port();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule